// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the interlock and bypass control for an in-order five-stage pipeline (fetch, decode, execute, memory, writeback). It looks only at register indices, write-enable flags, load and store flags, a writeback-valid flag and a mispredict flag from the execute stage. It never touches data. From these it derives the operand bypass multiplexer selects for the execute stage, a store-data bypass select for the memory stage, a hold for the PC and the fetch/decode register, a no-op insert for the decode/execute register, and kill signals for the two youngest pipeline registers when a branch turns out to be mispredicted.

A runtime input chooses between two policies. With bypassing on, results are steered from the execute/memory and memory/writeback registers, and only a load feeding the very next instruction costs a cycle. With bypassing off, every select stays on the register-file path and a consumer waits in decode until its producer reaches writeback. The register file is assumed to write early and read late in a cycle, so a producer in writeback never causes a stall. Three free-running counters report elapsed cycles, retired instructions and injected no-ops.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: With bypassing on, an execute-stage source that equals the execute/memory destination (write enabled, not a load) gets select 2'b01. A load held in execute/memory is never chosen as a bypass source.
- R2: With bypassing on, an execute-stage source that misses execute/memory but equals the memory/writeback destination (write enabled) gets select 2'b10. Otherwise the select is 2'b00 (register file).
- R3: When both the execute/memory and memory/writeback producers match the same source, select 2'b01 (the younger result) wins.
- R4: Register index 0 never produces a bypass select other than 2'b00 and never causes a stall.
- R5: With bypassing on, a store in execute/memory whose data register equals the destination of a load in memory/writeback raises `st_data_byp`, and this causes no stall.
- R6: With bypassing on, a decode-stage source that is used and equals the destination of a load in decode/execute raises `hold_front` and `insert_bubble`. A store's data operand (source 2 of a store) is exempt, and a non-load producer never stalls.
- R7: With bypassing off, all bypass selects and `st_data_byp` are 0. A used decode source that matches a writing producer in decode/execute or execute/memory stalls; a match only in memory/writeback does not; an unused source never stalls.
- R8: `ex_mispredict` raises `kill_ifid` and `kill_idex` in the same cycle and leaves the bypass selects unchanged.
- R9: A mispredict overrides a stall: while `ex_mispredict` is high, `hold_front` and `insert_bubble` are 0.
- R10: Reset clears all three counters; afterwards `cyc_cnt` grows by one on every clock.
- R11: `ret_cnt` grows by one on each clock where `mw_valid` is high. A hazard-free stream, valid in writeback from its fifth cycle, retires one instruction per cycle after four fill cycles.
- R12: `bub_cnt` grows by 1 on each stall cycle and by 2 on each mispredict cycle (two killed slots).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 = bypassing on, 0 = wait for writeback |
| id_rs1 | input | 5 | Decode source register 1 |
| id_rs2 | input | 5 | Decode source register 2 |
| id_use1 | input | 1 | Decode instruction reads source 1 |
| id_use2 | input | 1 | Decode instruction reads source 2 |
| id_is_store | input | 1 | Decode instruction is a store (source 2 is store data) |
| dx_rd | input | 5 | Decode/execute destination register |
| dx_we | input | 1 | Decode/execute writes a register |
| dx_load | input | 1 | Decode/execute is a load |
| dx_rs1 | input | 5 | Execute-stage source register 1 |
| dx_rs2 | input | 5 | Execute-stage source register 2 |
| xm_rd | input | 5 | Execute/memory destination register |
| xm_we | input | 1 | Execute/memory writes a register |
| xm_load | input | 1 | Execute/memory is a load |
| xm_store | input | 1 | Execute/memory is a store |
| xm_rs2 | input | 5 | Execute/memory store-data register |
| mw_rd | input | 5 | Memory/writeback destination register |
| mw_we | input | 1 | Memory/writeback writes a register |
| mw_load | input | 1 | Memory/writeback is a load |
| mw_valid | input | 1 | Memory/writeback holds a real instruction |
| ex_mispredict | input | 1 | Branch in execute was mispredicted |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 execute/memory, 10 memory/writeback |
| fwd_b | output | 2 | Operand B select, same encoding |
| st_data_byp | output | 1 | Memory-stage store data taken from memory/writeback |
| hold_front | output | 1 | Hold PC and fetch/decode register |
| insert_bubble | output | 1 | Load a no-op into decode/execute |
| kill_ifid | output | 1 | Flush fetch/decode register |
| kill_idex | output | 1 | Flush decode/execute register |
| cyc_cnt | output | 32 | Cycles since reset |
| ret_cnt | output | 32 | Retired instructions |
| bub_cnt | output | 32 | No-ops injected by stalls and flushes |

## Verification
The bypass selects are driven with a producer in only one of the two later stages, in both, and with a load in execute/memory, which separates the two bypass paths, their priority and the load exclusion. Stall logic is tried with a load producer, a non-load producer, a store whose data is the loaded register and an unused operand, with bypassing both on and off, so the load-use bubble can be told apart from the stall-until-writeback policy. Mispredicts are applied alone, on top of a load-use condition and alongside an active bypass, showing the kills, their priority over the stall and that the selects are left alone. A final run with a four-cycle fill followed by stalls and mispredicts checks the three counters cycle by cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

   typedef enum logic [1:0] {
      SRC_RF = 2'b00,
      SRC_XM = 2'b01,
      SRC_MW = 2'b10
   } byp_src_e;

   localparam int unsigned N_DEC_SRC = 2;
   localparam int unsigned N_CNT     = 3;

endpackage

// File: rtl/hz_byp_pick.sv
module hz_byp_pick
   import hz_pkg::*;
#(
   parameter int unsigned REG_AW = 5
) (
   input  logic              fwd_en,
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] xm_rd,
   input  logic              xm_we,
   input  logic              xm_load,
   input  logic [REG_AW-1:0] mw_rd,
   input  logic              mw_we,
   output byp_src_e          sel
);

   logic src_live;
   logic hit_xm;
   logic hit_mw;

   always_comb begin
      src_live = (src != '0);
      hit_xm   = fwd_en && src_live && xm_we && !xm_load && (xm_rd == src);
      hit_mw   = fwd_en && src_live && mw_we && (mw_rd == src);
      if (hit_xm)
         sel = SRC_XM;
      else if (hit_mw)
         sel = SRC_MW;
      else
         sel = SRC_RF;
   end

endmodule

// File: rtl/hz_stall_det.sv
module hz_stall_det
   import hz_pkg::*;
#(
   parameter int unsigned REG_AW = 5
) (
   input  logic              fwd_en,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              id_use1,
   input  logic              id_use2,
   input  logic              id_is_store,
   input  logic [REG_AW-1:0] dx_rd,
   input  logic              dx_we,
   input  logic              dx_load,
   input  logic [REG_AW-1:0] xm_rd,
   input  logic              xm_we,
   output logic              stall_req
);

   logic [REG_AW-1:0]    src    [N_DEC_SRC];
   logic [N_DEC_SRC-1:0] used;
   logic [N_DEC_SRC-1:0] exempt;
   logic [N_DEC_SRC-1:0] need;

   assign src[0]    = id_rs1;
   assign src[1]    = id_rs2;
   assign used      = {id_use2, id_use1};
   // store data is fixed up later by the memory-stage bypass
   assign exempt    = {id_is_store, 1'b0};

   for (genvar g = 0; g < N_DEC_SRC; g++) begin : g_src
      logic live;
      logic dx_hit;
      logic xm_hit;
      always_comb begin
         live   = used[g] && (src[g] != '0);
         dx_hit = dx_we && (dx_rd == src[g]);
         xm_hit = xm_we && (xm_rd == src[g]);
         if (fwd_en)
            need[g] = live && dx_hit && dx_load && !exempt[g];
         else
            need[g] = live && (dx_hit || xm_hit);
      end
   end

   assign stall_req = |need;

endmodule

// File: rtl/hz_counters.sv
module hz_counters
   import hz_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned FLUSH_SLOTS = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             retire,
   input  logic             stall,
   input  logic             flush,
   output logic [CNT_W-1:0] cyc_cnt,
   output logic [CNT_W-1:0] ret_cnt,
   output logic [CNT_W-1:0] bub_cnt
);

   localparam int unsigned STEP_W = $clog2(FLUSH_SLOTS + 1);

   logic [STEP_W-1:0] step [N_CNT];
   logic [CNT_W-1:0]  cnt  [N_CNT];

   always_comb begin
      step[0] = STEP_W'(1);
      step[1] = STEP_W'(retire);
      if (flush)
         step[2] = STEP_W'(FLUSH_SLOTS);
      else if (stall)
         step[2] = STEP_W'(1);
      else
         step[2] = '0;
   end

   for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (rst)
            cnt[g] <= '0;
         else
            cnt[g] <= cnt[g] + CNT_W'(step[g]);
      end
   end

   assign cyc_cnt = cnt[0];
   assign ret_cnt = cnt[1];
   assign bub_cnt = cnt[2];

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
   import hz_pkg::*;
#(
   parameter int unsigned REG_AW  = 5,
   parameter int unsigned CNT_W   = 32,
   parameter bit          HAS_M2M = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fwd_en,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              id_use1,
   input  logic              id_use2,
   input  logic              id_is_store,
   input  logic [REG_AW-1:0] dx_rd,
   input  logic              dx_we,
   input  logic              dx_load,
   input  logic [REG_AW-1:0] dx_rs1,
   input  logic [REG_AW-1:0] dx_rs2,
   input  logic [REG_AW-1:0] xm_rd,
   input  logic              xm_we,
   input  logic              xm_load,
   input  logic              xm_store,
   input  logic [REG_AW-1:0] xm_rs2,
   input  logic [REG_AW-1:0] mw_rd,
   input  logic              mw_we,
   input  logic              mw_load,
   input  logic              mw_valid,
   input  logic              ex_mispredict,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic              st_data_byp,
   output logic              hold_front,
   output logic              insert_bubble,
   output logic              kill_ifid,
   output logic              kill_idex,
   output logic [CNT_W-1:0]  cyc_cnt,
   output logic [CNT_W-1:0]  ret_cnt,
   output logic [CNT_W-1:0]  bub_cnt
);

   localparam int unsigned FLUSH_SLOTS = 2;

   initial begin
      if (REG_AW < 1 || REG_AW > 8)
         $fatal(1, "pipe_hazard_ctrl: REG_AW out of range");
      if (CNT_W < 4)
         $fatal(1, "pipe_hazard_ctrl: CNT_W too small");
   end

   // execute-stage operand selects
   logic [REG_AW-1:0] ex_src [N_DEC_SRC];
   byp_src_e          ex_sel [N_DEC_SRC];

   assign ex_src[0] = dx_rs1;
   assign ex_src[1] = dx_rs2;

   for (genvar g = 0; g < N_DEC_SRC; g++) begin : g_byp
      hz_byp_pick #(.REG_AW(REG_AW)) u_pick (
         .fwd_en  (fwd_en),
         .src     (ex_src[g]),
         .xm_rd   (xm_rd),
         .xm_we   (xm_we),
         .xm_load (xm_load),
         .mw_rd   (mw_rd),
         .mw_we   (mw_we),
         .sel     (ex_sel[g])
      );
   end

   assign fwd_a = ex_sel[0];
   assign fwd_b = ex_sel[1];

   // memory-stage store-data bypass
   if (HAS_M2M) begin : g_m2m
      assign st_data_byp = fwd_en && xm_store && mw_we && mw_load &&
                           (xm_rs2 != '0) && (xm_rs2 == mw_rd);
   end else begin : g_no_m2m
      assign st_data_byp = 1'b0;
   end

   // interlock
   logic stall_req;

   hz_stall_det #(.REG_AW(REG_AW)) u_stall (
      .fwd_en      (fwd_en),
      .id_rs1      (id_rs1),
      .id_rs2      (id_rs2),
      .id_use1     (id_use1),
      .id_use2     (id_use2),
      .id_is_store (HAS_M2M ? id_is_store : 1'b0),
      .dx_rd       (dx_rd),
      .dx_we       (dx_we),
      .dx_load     (dx_load),
      .xm_rd       (xm_rd),
      .xm_we       (xm_we),
      .stall_req   (stall_req)
   );

   // a wrong-path instruction is never worth waiting for
   assign hold_front    = stall_req && !ex_mispredict;
   assign insert_bubble = hold_front;
   assign kill_ifid     = ex_mispredict;
   assign kill_idex     = ex_mispredict;

   hz_counters #(.CNT_W(CNT_W), .FLUSH_SLOTS(FLUSH_SLOTS)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .retire  (mw_valid),
      .stall   (hold_front),
      .flush   (ex_mispredict),
      .cyc_cnt (cyc_cnt),
      .ret_cnt (ret_cnt),
      .bub_cnt (bub_cnt)
   );

endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
   parameter int unsigned REG_AW  = 5,
   parameter int unsigned CNT_W   = 32,
   parameter bit          HAS_M2M = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              fwd_en,
   input logic [REG_AW-1:0] id_rs1,
   input logic              id_use1,
   input logic [REG_AW-1:0] dx_rd,
   input logic              dx_we,
   input logic              dx_load,
   input logic [REG_AW-1:0] dx_rs1,
   input logic [REG_AW-1:0] dx_rs2,
   input logic              mw_valid,
   input logic              ex_mispredict,
   input logic [1:0]        fwd_a,
   input logic [1:0]        fwd_b,
   input logic              st_data_byp,
   input logic              hold_front,
   input logic              insert_bubble,
   input logic [CNT_W-1:0]  cyc_cnt,
   input logic [CNT_W-1:0]  ret_cnt
);

   assert_r0_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      (dx_rs1 == '0) |-> (fwd_a == 2'b00 && (dx_rs2 != '0 || fwd_b == 2'b00)));

   assert_bypass_off_R7: assert property (@(posedge clk) disable iff (rst)
      !fwd_en |-> (fwd_a == 2'b00 && fwd_b == 2'b00 && !st_data_byp));

   assert_load_use_R6: assert property (@(posedge clk) disable iff (rst)
      (fwd_en && dx_load && dx_we && dx_rd != '0 && id_use1 &&
       id_rs1 == dx_rd && !ex_mispredict) |-> (hold_front && insert_bubble));

   assert_kill_wins_R9: assert property (@(posedge clk) disable iff (rst)
      ex_mispredict |-> (!hold_front && !insert_bubble));

   assert_cycle_step_R10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));

   assert_retire_step_R11: assert property (@(posedge clk) disable iff (rst)
      mw_valid |=> (ret_cnt == $past(ret_cnt) + 1'b1));

endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(
   .REG_AW (REG_AW),
   .CNT_W  (CNT_W),
   .HAS_M2M(HAS_M2M)
) u_chk (.*);

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic       fwd_en;
      logic [4:0] id_rs1;
      logic [4:0] id_rs2;
      logic       id_use1;
      logic       id_use2;
      logic       id_is_store;
      logic [4:0] dx_rd;
      logic       dx_we;
      logic       dx_load;
      logic [4:0] dx_rs1;
      logic [4:0] dx_rs2;
      logic [4:0] xm_rd;
      logic       xm_we;
      logic       xm_load;
      logic       xm_store;
      logic [4:0] xm_rs2;
      logic [4:0] mw_rd;
      logic       mw_we;
      logic       mw_load;
      logic       mw_valid;
      logic       ex_mis;
   } vec_t;

   typedef struct {
      logic [8:0] exp;
      string      req;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   vec_t cur = '0;

   logic [1:0]  fwd_a, fwd_b;
   logic        st_data_byp, hold_front, insert_bubble, kill_ifid, kill_idex;
   logic [31:0] cyc_cnt, ret_cnt, bub_cnt;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   item_t sb[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   pipe_hazard_ctrl i_pipe_hazard_ctrl (
      .clk           (clk),
      .rst           (rst),
      .fwd_en        (cur.fwd_en),
      .id_rs1        (cur.id_rs1),
      .id_rs2        (cur.id_rs2),
      .id_use1       (cur.id_use1),
      .id_use2       (cur.id_use2),
      .id_is_store   (cur.id_is_store),
      .dx_rd         (cur.dx_rd),
      .dx_we         (cur.dx_we),
      .dx_load       (cur.dx_load),
      .dx_rs1        (cur.dx_rs1),
      .dx_rs2        (cur.dx_rs2),
      .xm_rd         (cur.xm_rd),
      .xm_we         (cur.xm_we),
      .xm_load       (cur.xm_load),
      .xm_store      (cur.xm_store),
      .xm_rs2        (cur.xm_rs2),
      .mw_rd         (cur.mw_rd),
      .mw_we         (cur.mw_we),
      .mw_load       (cur.mw_load),
      .mw_valid      (cur.mw_valid),
      .ex_mispredict (cur.ex_mis),
      .fwd_a         (fwd_a),
      .fwd_b         (fwd_b),
      .st_data_byp   (st_data_byp),
      .hold_front    (hold_front),
      .insert_bubble (insert_bubble),
      .kill_ifid     (kill_ifid),
      .kill_idex     (kill_idex),
      .cyc_cnt       (cyc_cnt),
      .ret_cnt       (ret_cnt),
      .bub_cnt       (bub_cnt)
   );

   // result packing: {fwd_a, fwd_b, st_data_byp, hold, bubble, kill_ifid, kill_idex}
   task automatic drv(input vec_t v, input logic [8:0] e, input string r);
      item_t it;
      @(negedge clk);
      cur    = v;
      it.exp = e;
      it.req = r;
      sb.push_back(it);
   endtask

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", r, act, exp);
      end
   endtask

   // monitor: compares the design's outputs against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            logic [8:0] act;
            it  = sb.pop_front();
            act = {fwd_a, fwd_b, st_data_byp, hold_front, insert_bubble, kill_ifid, kill_idex};
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: got %b expected %b", it.req, act, it.exp);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R10 reset cyc", cyc_cnt, 0);
      chk("R11 reset ret", ret_cnt, 0);
      chk("R12 reset bub", bub_cnt, 0);

      // R4: index 0 everywhere, bypassing on
      v = '0; v.fwd_en = 1; v.id_use1 = 1; v.dx_we = 1; v.dx_load = 1;
      v.xm_we = 1; v.mw_we = 1;
      drv(v, 9'b00_00_0_0_0_0_0, "R4 zero reg bypass on");

      // R1: execute/memory producer
      v = '0; v.fwd_en = 1; v.dx_rs1 = 5; v.xm_rd = 5; v.xm_we = 1;
      drv(v, 9'b01_00_0_0_0_0_0, "R1 xm to A");

      // R2: memory/writeback producer
      v = '0; v.fwd_en = 1; v.dx_rs2 = 7; v.mw_rd = 7; v.mw_we = 1;
      drv(v, 9'b00_10_0_0_0_0_0, "R2 mw to B");

      // R3: both match, younger wins
      v = '0; v.fwd_en = 1; v.dx_rs1 = 3; v.xm_rd = 3; v.xm_we = 1;
      v.mw_rd = 3; v.mw_we = 1;
      drv(v, 9'b01_00_0_0_0_0_0, "R3 priority");

      // R1: load in execute/memory is not a source
      v = '0; v.fwd_en = 1; v.dx_rs2 = 4; v.xm_rd = 4; v.xm_we = 1; v.xm_load = 1;
      drv(v, 9'b00_00_0_0_0_0_0, "R1 load not bypassed");

      // R5: store data from load in writeback
      v = '0; v.fwd_en = 1; v.xm_store = 1; v.xm_rs2 = 6; v.mw_rd = 6;
      v.mw_we = 1; v.mw_load = 1;
      drv(v, 9'b00_00_1_0_0_0_0, "R5 mem to mem");

      // R6: load-use
      v = '0; v.fwd_en = 1; v.id_rs1 = 8; v.id_use1 = 1; v.dx_rd = 8;
      v.dx_we = 1; v.dx_load = 1;
      drv(v, 9'b00_00_0_1_1_0_0, "R6 load use");

      // R6: store data exempt
      v = '0; v.fwd_en = 1; v.id_is_store = 1; v.id_rs1 = 2; v.id_use1 = 1;
      v.id_rs2 = 8; v.id_use2 = 1; v.dx_rd = 8; v.dx_we = 1; v.dx_load = 1;
      drv(v, 9'b00_00_0_0_0_0_0, "R6 store data exempt");

      // R6: non-load producer does not stall
      v = '0; v.fwd_en = 1; v.id_rs1 = 8; v.id_use1 = 1; v.dx_rd = 8; v.dx_we = 1;
      drv(v, 9'b00_00_0_0_0_0_0, "R6 alu producer");

      // R7: bypassing off, decode/execute match
      v = '0; v.id_rs1 = 9; v.id_use1 = 1; v.dx_rd = 9; v.dx_we = 1;
      v.dx_rs1 = 5; v.xm_rd = 5; v.xm_we = 1;
      drv(v, 9'b00_00_0_1_1_0_0, "R7 off dx match");

      // R7: bypassing off, execute/memory match
      v = '0; v.id_rs2 = 9; v.id_use2 = 1; v.xm_rd = 9; v.xm_we = 1;
      drv(v, 9'b00_00_0_1_1_0_0, "R7 off xm match");

      // R7: bypassing off, writeback match only
      v = '0; v.id_rs1 = 9; v.id_use1 = 1; v.mw_rd = 9; v.mw_we = 1; v.mw_load = 1;
      v.dx_rs1 = 9; v.xm_store = 1; v.xm_rs2 = 9;
      drv(v, 9'b00_00_0_0_0_0_0, "R7 off mw no stall");

      // R7: unused operand
      v = '0; v.id_rs1 = 9; v.dx_rd = 9; v.dx_we = 1;
      drv(v, 9'b00_00_0_0_0_0_0, "R7 unused src");

      // R4: index 0 with bypassing off
      v = '0; v.id_use1 = 1; v.dx_we = 1; v.xm_we = 1;
      drv(v, 9'b00_00_0_0_0_0_0, "R4 zero reg bypass off");

      // R8: mispredict
      v = '0; v.fwd_en = 1; v.ex_mis = 1;
      drv(v, 9'b00_00_0_0_0_1_1, "R8 kill");

      // R9: mispredict over load-use
      v = '0; v.fwd_en = 1; v.ex_mis = 1; v.id_rs1 = 8; v.id_use1 = 1;
      v.dx_rd = 8; v.dx_we = 1; v.dx_load = 1;
      drv(v, 9'b00_00_0_0_0_1_1, "R9 kill over stall");

      // R8: selects unaffected by kill
      v = '0; v.fwd_en = 1; v.ex_mis = 1; v.dx_rs1 = 5; v.xm_rd = 5; v.xm_we = 1;
      drv(v, 9'b01_00_0_0_0_1_1, "R8 selects kept");

      @(negedge clk);
      cur = '0;
      @(negedge clk);
      #3;

      // counter phase
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 20; i++) begin
         cur = '0;
         cur.mw_valid = (i >= 4);
         @(negedge clk);
         #1;
         chk("R11 fill ret", ret_cnt, (i >= 4) ? i - 3 : 0);
      end
      chk("R10 cycles", cyc_cnt, 20);
      chk("R12 no bubbles", bub_cnt, 0);

      for (int i = 0; i < 3; i++) begin
         cur = '0; cur.fwd_en = 1; cur.id_rs1 = 8; cur.id_use1 = 1;
         cur.dx_rd = 8; cur.dx_we = 1; cur.dx_load = 1;
         @(negedge clk);
      end
      for (int i = 0; i < 2; i++) begin
         cur = '0; cur.ex_mis = 1;
         @(negedge clk);
      end
      cur = '0;
      #1;
      chk("R10 cycles later", cyc_cnt, 25);
      chk("R11 ret held", ret_cnt, 16);
      chk("R12 bubbles", bub_cnt, 7);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule